// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit works out the address of a memory operand. Each cycle that `in_valid` is high it takes a segment value, a base register, an index register, a displacement, an addressing mode and an access size. From these it forms a 16-bit effective address (the offset inside the segment) and a 20-bit physical address. The physical address is the segment value moved up by four bit positions plus the offset. The unit also checks whether the access is naturally aligned for its size and reports the result. A misaligned access still gets its address.

All results are registered. A small two-state controller follows the handshake. `ST_IDLE` means no fresh result is on the outputs. `ST_RESULT` means the outputs hold the address for the operand accepted on the previous edge. The controller has four transitions:

- `ST_IDLE` goes to `ST_RESULT` on an edge where `in_valid` is high.
- `ST_RESULT` stays in `ST_RESULT` on an edge where `in_valid` is high.
- `ST_RESULT` goes back to `ST_IDLE` on an edge where `in_valid` is low.
- `ST_IDLE` stays in `ST_IDLE` on an edge where `in_valid` is low.

`out_valid` is high exactly while the controller is in `ST_RESULT`. Reading the register file, segment tables, paging and bus cycles are all outside this unit.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operand, `out_valid`, `ea`, `phys` and `misaligned` are all zero.
- R2: An operand presented with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for that one cycle. After an edge where `in_valid` is low, `out_valid` is low and `ea`, `phys` and `misaligned` keep their previous values.
- R3: Mode code 0 (direct) gives `ea` = `disp`.
- R4: Mode code 1 (register indirect) gives `ea` = `index_reg` when `ind_sel` is 0, and `ea` = `base_reg` when `ind_sel` is 1.
- R5: Mode code 2 (based) gives `ea` = `base_reg` + `disp`. Mode code 3 (indexed) gives `ea` = `index_reg` + `disp`. Both sums wrap modulo 2^16.
- R6: Mode code 4 (based-indexed) gives `ea` = `base_reg` + `index_reg` + `disp`, wrapping modulo 2^16.
- R7: The reserved mode codes 5, 6 and 7 give the same result as direct mode (`ea` = `disp`).
- R8: `phys` = `seg_base` × 16 + `ea`, wrapping modulo 2^20. For example, segment 0x1000 with offset 0x1234 gives 0x11234.
- R9: `misaligned` depends on the size code. Code 0 (byte) never sets it. Code 1 (word) sets it when `ea` bit 0 is 1. Codes 2 and 3 (double word) set it when `ea` bits 1:0 are not zero. The address outputs are delivered whether or not the access is misaligned.
- R10: Two different segment/offset pairs that name the same physical location produce the same `phys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| mode | input | 3 | Addressing mode code |
| size | input | 2 | Access size code |
| ind_sel | input | 1 | Register to use in register-indirect mode: 0 = index, 1 = base |
| seg_base | input | 16 | Segment value |
| base_reg | input | 16 | Base register value |
| index_reg | input | 16 | Index register value |
| disp | input | 16 | Displacement |
| out_valid | output | 1 | A result is on the outputs this cycle |
| ea | output | 16 | Effective address (offset) |
| phys | output | 20 | Physical address |
| misaligned | output | 1 | The access is not aligned for its size |

## Verification
Every result arrives one rising edge after its operand is accepted, because the path has a single register stage. The bench drives inputs on the falling edge and captures the expected result at the rising edge when `in_valid` is high. It compares all four outputs at the next falling edge, so each comparison lands in the first cycle the result is visible. On cycles where `in_valid` is low, the reference keeps its previous values. The hold behaviour and the drop of `out_valid` are therefore checked at that same one-cycle offset.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT    = 3'd0,
        AM_REG_IND   = 3'd1,
        AM_BASED     = 3'd2,
        AM_INDEXED   = 3'd3,
        AM_BASED_IDX = 3'd4
    } addr_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/sag_ea_unit.sv
module sag_ea_unit #(
    parameter int OFS_W = 16
) (
    input  logic [2:0]       mode,
    input  logic             ind_sel,
    input  logic [OFS_W-1:0] base_reg,
    input  logic [OFS_W-1:0] index_reg,
    input  logic [OFS_W-1:0] disp,
    output logic [OFS_W-1:0] ea
);
    import seg_addr_pkg::*;

    logic [OFS_W-1:0] reg_pick;
    logic [OFS_W-1:0] term_a;
    logic [OFS_W-1:0] term_b;
    logic [OFS_W-1:0] term_c;

    assign reg_pick = ind_sel ? base_reg : index_reg;

    // Pick up to three addends; unused ones are zero. Sum wraps at OFS_W bits.
    always_comb begin
        term_a = '0;
        term_b = '0;
        term_c = disp;
        unique case (mode)
            AM_REG_IND: begin
                term_a = reg_pick;
                term_c = '0;
            end
            AM_BASED:     term_a = base_reg;
            AM_INDEXED:   term_a = index_reg;
            AM_BASED_IDX: begin
                term_a = base_reg;
                term_b = index_reg;
            end
            default: ;
        endcase
    end

    assign ea = term_a + term_b + term_c;

endmodule

// File: rtl/sag_phys_unit.sv
module sag_phys_unit #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0] seg_base,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] seg_scaled;
    logic [PA_W-1:0] ofs_ext;

    assign seg_scaled = {seg_base, {SEG_SHIFT{1'b0}}};

    generate
        if (OFS_W >= PA_W) begin : g_trunc
            assign ofs_ext = ofs[PA_W-1:0];
        end else begin : g_zext
            assign ofs_ext = {{(PA_W-OFS_W){1'b0}}, ofs};
        end
    endgenerate

    assign phys = seg_scaled + ofs_ext;

endmodule

// File: rtl/sag_align_unit.sv
module sag_align_unit #(
    parameter int OFS_W = 16
) (
    input  logic [1:0]       size,
    input  logic [OFS_W-1:0] ea,
    output logic             misaligned
);
    import seg_addr_pkg::*;

    always_comb begin
        unique case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_WORD:  misaligned = ea[0];
            default:  misaligned = |ea[1:0];
        endcase
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = SEG_W + SEG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       mode,
    input  logic [1:0]       size,
    input  logic             ind_sel,
    input  logic [SEG_W-1:0] seg_base,
    input  logic [OFS_W-1:0] base_reg,
    input  logic [OFS_W-1:0] index_reg,
    input  logic [OFS_W-1:0] disp,
    output logic             out_valid,
    output logic [OFS_W-1:0] ea,
    output logic [PA_W-1:0]  phys,
    output logic             misaligned
);
    import seg_addr_pkg::*;

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [OFS_W-1:0] ea_c;
    logic [PA_W-1:0]  phys_c;
    logic             mis_c;

    sag_ea_unit #(.OFS_W(OFS_W)) u_ea (
        .mode      (mode),
        .ind_sel   (ind_sel),
        .base_reg  (base_reg),
        .index_reg (index_reg),
        .disp      (disp),
        .ea        (ea_c)
    );

    sag_phys_unit #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
        .seg_base (seg_base),
        .ofs      (ea_c),
        .phys     (phys_c)
    );

    sag_align_unit #(.OFS_W(OFS_W)) u_align (
        .size       (size),
        .ea         (ea_c),
        .misaligned (mis_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea         <= '0;
            phys       <= '0;
            misaligned <= 1'b0;
        end else if (in_valid) begin
            ea         <= ea_c;
            phys       <= phys_c;
            misaligned <= mis_c;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  mode,
    input logic [1:0]  size,
    input logic [15:0] disp,
    input logic        out_valid,
    input logic [15:0] ea,
    input logic [19:0] phys,
    input logic        misaligned
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea) && $stable(phys) && $stable(misaligned)));

    // R3
    direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0) |=> (ea == $past(disp)));

    // R8
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (phys[3:0] == ea[3:0]));

    // R9
    byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd0) |=> !misaligned);

    // R9
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd1) |=> (misaligned == ea[0]));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .size       (size),
    .disp       (disp),
    .out_valid  (out_valid),
    .ea         (ea),
    .phys       (phys),
    .misaligned (misaligned)
);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        ind_sel = 1'b0;
    logic [15:0] seg_base = '0;
    logic [15:0] base_reg = '0;
    logic [15:0] index_reg = '0;
    logic [15:0] disp = '0;
    logic        out_valid;
    logic [15:0] ea;
    logic [19:0] phys;
    logic        misaligned;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    logic        x_valid = 0;
    logic [15:0] x_ea = 0;
    logic [19:0] x_phys = 0;
    logic        x_mis = 0;
    string       x_tag = "R1";

    always #5 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
        .ind_sel(ind_sel), .seg_base(seg_base), .base_reg(base_reg),
        .index_reg(index_reg), .disp(disp), .out_valid(out_valid), .ea(ea),
        .phys(phys), .misaligned(misaligned)
    );

    // Behavioural reference, updated at the edge that accepts an operand.
    always @(posedge clk) begin
        int unsigned s;
        started = 1;
        if (!rst_n) begin
            x_valid = 0; x_ea = 0; x_phys = 0; x_mis = 0; x_tag = "R1";
        end else if (!in_valid) begin
            x_valid = 0; x_tag = "R2";
        end else begin
            case (mode)
                3'd1: begin s = ind_sel ? base_reg : index_reg; x_tag = "R4"; end
                3'd2: begin s = base_reg + disp; x_tag = "R5"; end
                3'd3: begin s = index_reg + disp; x_tag = "R5"; end
                3'd4: begin s = base_reg + index_reg + disp; x_tag = "R6"; end
                3'd0: begin s = disp; x_tag = "R3"; end
                default: begin s = disp; x_tag = "R7"; end
            endcase
            x_valid = 1;
            x_ea = s % 65536;
            x_phys = (seg_base * 16 + x_ea) % (1 << 20);
            if (size == 2'd0)      x_mis = 0;
            else if (size == 2'd1) x_mis = x_ea[0];
            else                   x_mis = (x_ea % 4) != 0;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (out_valid !== x_valid || ea !== x_ea || misaligned !== x_mis) begin
                n_bad++;
                $display("FAIL %s: valid/ea/mis = %0b/%h/%0b expected %0b/%h/%0b",
                         x_tag, out_valid, ea, misaligned, x_valid, x_ea, x_mis);
            end else if (phys !== x_phys) begin
                n_bad++;
                $display("FAIL R8 (%s): phys = %h expected %h", x_tag, phys, x_phys);
            end
        end
    end

    task automatic put(input logic [2:0] m, input logic [1:0] sz, input logic sel,
                       input logic [15:0] sg, input logic [15:0] b,
                       input logic [15:0] ix, input logic [15:0] d);
        in_valid = 1; mode = m; size = sz; ind_sel = sel;
        seg_base = sg; base_reg = b; index_reg = ix; disp = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        mode = 3'd4; seg_base = 16'hABCD; disp = 16'h5555;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_phys(input string tag, input logic [19:0] want);
        @(negedge clk);
        n_vec++;
        if (phys !== want) begin
            n_bad++;
            $display("FAIL %s: phys = %h expected %h", tag, phys, want);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);          // R1: reset state compared each cycle
        rst_n = 1;
        idle(2);                             // R1/R2: still zero after release
        put(3'd0, 2'd0, 0, 16'h1000, 16'h0, 16'h0, 16'h1234);   // R8 example
        in_valid = 0; expect_phys("R8", 20'h11234);
        put(3'd5, 2'd0, 0, 16'h1123, 16'h0, 16'h0, 16'h0004);   // R10 alias
        in_valid = 0; expect_phys("R10", 20'h11234);
        put(3'd1, 2'd1, 0, 16'h0200, 16'h1111, 16'h2223, 16'h9);  // R4 index
        put(3'd1, 2'd2, 1, 16'h0200, 16'h1116, 16'h2223, 16'h9);  // R4 base
        put(3'd2, 2'd2, 0, 16'h0000, 16'hFFFF, 16'h0, 16'h0005);  // R5 wrap
        put(3'd3, 2'd1, 0, 16'h0001, 16'h0, 16'h8000, 16'h8002);  // R5 wrap
        put(3'd4, 2'd3, 0, 16'h0010, 16'hFFFF, 16'h0002, 16'h0);  // R6 wrap
        put(3'd6, 2'd1, 1, 16'h0, 16'h7, 16'h7, 16'h0003);        // R7
        put(3'd7, 2'd2, 0, 16'h0, 16'h7, 16'h7, 16'h0004);        // R7
        put(3'd0, 2'd0, 0, 16'hFFFF, 16'h0, 16'h0, 16'h0020);     // R8 wrap
        idle(3);                                                  // R2 hold
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0) idle(1);
            else put(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom),
                     16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        end
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule